// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter. It drives a trial code to an external DAC and reads back one comparator bit that tells whether the sampled input lies at or above the DAC level. It settles one bit per clock, starting at the most significant bit and ending at bit 0. When the last bit is settled, it copies the code into a held result buffer and raises an end-of-conversion flag.

The start input is level-sensitive. While start is low, the trial code is forced to zero and any conversion in progress is dropped. Raising start begins a conversion. The end-of-conversion flag then stays high until start is lowered again. Lowering start and raising it again begins the next conversion.

The sequencer has three states:
- IDLE: trial code cleared.
- CONV: one bit decided per clock.
- DONE: end-of-conversion high, trial code held.

It has five transitions:
- IDLE→CONV (start high).
- CONV→CONV (more bits to decide).
- CONV→DONE (bit 0 decided).
- CONV→IDLE (start dropped, conversion abandoned).
- DONE→IDLE (start lowered).

Top module: `sar_conv_ctrl`

## Requirements
- R1: On any rising clock edge at which start is low, the trial code becomes all zeros.
- R2: On the first rising edge at which start is sampled high in IDLE, the trial code becomes 1000_0000.
- R3: The comparator is sampled on the edge after a trial code is applied. A 1 (input at or above the DAC level) keeps the bit under test set, and a 0 clears it.
- R4: On the same edge as a decision, the next lower bit is set for trial, so bits are settled strictly from bit 7 down to bit 0 (for an input of 200 the codes run 0x80, then 0xC0).
- R5: EOC is high after the 9th rising edge at which start is sampled high, counting from IDLE. It is low after the 8th.
- R6: The result output changes only when a conversion completes. It keeps its previous value throughout a new conversion.
- R7: While EOC is high and start stays high, EOC stays high and the trial code holds the final code. The first edge with start low drops EOC. A new conversion needs start to go low and then high again.
- R8: Lowering start before bit 0 is decided abandons the conversion. EOC does not rise and the result is unchanged.
- R9: With an ideal comparator (high when input ≥ trial code), every input level from 0 to 255 gives a result equal to the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Level-sensitive conversion request |
| cmp_above | input | 1 | Comparator: 1 when input is at or above DAC level |
| dac_code | output | 8 | Trial code driven to the DAC |
| result | output | 8 | Held result of the last completed conversion |
| eoc | output | 1 | End of conversion |

## Verification
The trial code is due one edge after each input change. The first code, 0x80, appears after the first edge with start high, and each later code appears one edge after the comparator level that decided it. EOC and the new result are due together after the ninth edge, and the trial code and EOC clear one edge after start falls. The bench drives inputs 1 ns after a rising edge and samples 3 ns after the next one. A behavioural model, advanced on the same edges, is compared with every output on each clock. Explicit checks are placed at edge 8 (EOC still low, old result) and edge 9 (EOC high, new result) of every conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_DONE = 2'd2
    } sar_state_t;
endpackage

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int W  = 8,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          trial_clr,
    output logic          trial_init,
    output logic          trial_step,
    output logic [IW-1:0] bit_idx,
    output logic          latch_en,
    output logic          eoc
);
    localparam logic [IW-1:0] TOP_IDX = IW'(W - 1);

    sar_state_t state_q, state_d;
    logic [IW-1:0] idx_q;

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_CONV;
            ST_CONV: begin
                if (!start)           state_d = ST_IDLE;
                else if (idx_q == '0) state_d = ST_DONE;
            end
            ST_DONE: if (!start) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and bit pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= TOP_IDX;
        end else begin
            state_q <= state_d;
            if (trial_init)
                idx_q <= TOP_IDX;
            else if (trial_step && idx_q != '0)
                idx_q <= idx_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        trial_clr  = !start;
        trial_init = (state_q == ST_IDLE) && start;
        trial_step = (state_q == ST_CONV) && start;
        latch_en   = trial_step && (idx_q == '0);
        eoc        = (state_q == ST_DONE);
        bit_idx    = idx_q;
    end

    assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && start) |=> eoc);
    assert_start_low_drops_eoc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !eoc);
    assert_abort_no_eoc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV && !start) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
    parameter int W  = 8,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          init,
    input  logic          step,
    input  logic [IW-1:0] idx,
    input  logic          cmp,
    output logic [W-1:0]  code_q,
    output logic [W-1:0]  code_d
);
    localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        code_d = code_q;
        if (clr) begin
            code_d = '0;
        end else if (init) begin
            code_d = MSB_ONLY;
        end else if (step) begin
            code_d[idx] = cmp;
            if (idx != '0)
                code_d[idx - 1'b1] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_d;
    end

    assert_clear_on_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (code_q == '0));
    assert_keep_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cmp) |=> code_q[$past(idx)]);
    assert_drop_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cmp) |=> !code_q[$past(idx)]);
    assert_next_bit_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && idx != '0) |=> code_q[$past(idx) - 1'b1]);
endmodule

// File: rtl/sar_hold.sv
module sar_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         latch_en,
    input  logic [W-1:0] fin_code,
    output logic [W-1:0] result
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        result <= '0;
        else if (latch_en) result <= fin_code;
    end

    assert_result_only_on_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $past(latch_en));
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         cmp_above,
    output logic [W-1:0] dac_code,
    output logic [W-1:0] result,
    output logic         eoc
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;
    localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

    logic          t_clr, t_init, t_step, l_en;
    logic [IW-1:0] b_idx;
    logic [W-1:0]  code_next;

    sar_seq #(.W(W), .IW(IW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .trial_clr(t_clr), .trial_init(t_init), .trial_step(t_step),
        .bit_idx(b_idx), .latch_en(l_en), .eoc(eoc)
    );

    sar_trial #(.W(W), .IW(IW)) u_trial (
        .clk(clk), .rst_n(rst_n), .clr(t_clr), .init(t_init), .step(t_step),
        .idx(b_idx), .cmp(cmp_above), .code_q(dac_code), .code_d(code_next)
    );

    sar_hold #(.W(W)) u_hold (
        .clk(clk), .rst_n(rst_n), .latch_en(l_en),
        .fin_code(code_next), .result(result)
    );

    assert_first_trial_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        t_init |=> (dac_code == MSB_ONLY));
    assert_latch_raises_eoc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        l_en |=> (eoc && result == dac_code));
endmodule

// File: tb/tb_sar_conv_ctrl.sv
module tb_sar_conv_ctrl;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    int           vin = 0;
    logic         cmp_above;
    logic [W-1:0] dac_code, result;
    logic         eoc;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    assign cmp_above = (vin >= int'(dac_code));

    sar_conv_ctrl #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_above(cmp_above),
        .dac_code(dac_code), .result(result), .eoc(eoc)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model, advanced on each rising edge
    int  m_code = 0, m_res = 0, m_step = 0;
    bit  m_busy = 0, m_eoc = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_code = 0; m_res = 0; m_step = 0; m_busy = 0; m_eoc = 0;
        end else begin
            if (!start) begin
                m_code = 0; m_busy = 0; m_eoc = 0; m_step = 0;
            end else if (m_eoc) begin
                // hold
            end else if (!m_busy) begin
                m_busy = 1; m_code = 1 << (W - 1); m_step = W - 1;
            end else begin
                if (!(vin >= m_code)) m_code = m_code & ~(1 << m_step);
                if (m_step > 0) begin
                    m_code = m_code | (1 << (m_step - 1));
                    m_step = m_step - 1;
                end else begin
                    m_res = m_code; m_eoc = 1; m_busy = 0;
                end
            end
            #3;
            if (!finished) begin
                chk(int'(dac_code) == m_code, "R1/R2/R3/R4 model dac_code", int'(dac_code), m_code);
                chk(int'(result) == m_res, "R6 model result", int'(result), m_res);
                chk(eoc == m_eoc, "R5/R7 model eoc", int'(eoc), int'(m_eoc));
            end
        end
    end

    task automatic drive(input bit s, input int v);
        @(posedge clk); #1;
        start = s; vin = v;
    endtask

    task automatic after_edges(input int k);
        repeat (k) @(posedge clk);
        #3;
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int prev;
        #23;
        chk(dac_code == '0, "reset dac_code", int'(dac_code), 0);
        chk(result == '0, "reset result", int'(result), 0);
        chk(eoc == 1'b0, "reset eoc", int'(eoc), 0);
        rst_n = 1'b1;
        after_edges(2);

        // R2 / R4 trial sequence for input 200
        drive(1'b1, 200);
        after_edges(1);
        chk(dac_code == 8'h80, "R2 first trial", int'(dac_code), 8'h80);
        after_edges(1);
        chk(dac_code == 8'hC0, "R4 second trial", int'(dac_code), 8'hC0);
        after_edges(1);
        chk(dac_code == 8'hE0, "R3 keep bit6", int'(dac_code), 8'hE0);
        after_edges(1);
        chk(dac_code == 8'hD0, "R3 drop bit5", int'(dac_code), 8'hD0);
        after_edges(5);
        chk(eoc == 1'b1, "R5 eoc at edge 9", int'(eoc), 1);
        chk(int'(result) == 200, "R9 result 200", int'(result), 200);
        after_edges(3);
        chk(eoc == 1'b1, "R7 eoc held", int'(eoc), 1);
        chk(int'(dac_code) == 200, "R7 code held", int'(dac_code), 200);
        drive(1'b0, 200);
        after_edges(1);
        chk(eoc == 1'b0, "R7 eoc drops", int'(eoc), 0);
        chk(dac_code == '0, "R1 code cleared", int'(dac_code), 0);

        // R8 abort mid-conversion
        drive(1'b1, 77);
        after_edges(4);
        drive(1'b0, 77);
        after_edges(1);
        chk(dac_code == '0, "R1 cleared on abort", int'(dac_code), 0);
        after_edges(8);
        chk(eoc == 1'b0, "R8 no eoc after abort", int'(eoc), 0);
        chk(int'(result) == 200, "R8 result unchanged", int'(result), 200);

        // R9 full sweep with R5/R6 timing
        prev = 200;
        for (int v = 0; v < 256; v++) begin
            drive(1'b1, v);
            after_edges(8);
            chk(eoc == 1'b0, "R5 eoc low at edge 8", int'(eoc), 0);
            chk(int'(result) == prev, "R6 result held during conversion", int'(result), prev);
            after_edges(1);
            chk(eoc == 1'b1, "R5 eoc high at edge 9", int'(eoc), 1);
            chk(int'(result) == v, "R9 result equals input", int'(result), v);
            drive(1'b0, v);
            after_edges(1);
            chk(eoc == 1'b0, "R7 eoc low after start low", int'(eoc), 0);
            chk(dac_code == '0, "R1 trial cleared", int'(dac_code), 0);
            prev = v;
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule